// File: doc/BRIEF.md
# Touch Strength Integrator and Selector

This block turns a stream of per-sample touch flags from several capacitive sensing channels into a stable touch byte. While filtering is on, it counts, for each channel, how many samples in a programmable integration window carried a touch flag. That count is the channel's strength. Once per window it picks the channels that count as touched. Only channels whose strength is above their own threshold can be picked. Among those, a 2-bit mode keeps the single strongest channel, all of them, or the two strongest. An optional second stage then steadies the result: it counts how often each channel was picked over a run of windows and reports a touch only when that count is above a threshold. When filtering is off, the raw flags pass straight to the touch byte.

Each change of the touch byte is pushed into a four-entry event FIFO. An entry is two bytes: the low byte is the touch byte, with bit n for channel n, and the high byte is zero. A reader pops the oldest entry through `fifo_pop`.

A three-state sequencer orders the work. `ST_RUN` waits for `sample_tick`. On a tick that ends a window it moves to `ST_SELECT`; with filtering off, any tick moves it to `ST_EMIT`. `ST_SELECT` runs the pick and the second stage. When a new candidate byte is ready it moves to `ST_EMIT`; in the middle of a second-stage run it returns to `ST_RUN`. `ST_EMIT` updates the touch byte, pushes an entry if the byte changed, and always returns to `ST_RUN`. Sample ticks must be at least three clock cycles apart; ticks that arrive outside `ST_RUN` are not counted.

Top module: `touch_strength_sel`

## Requirements
- R1: After reset every strength is 0, `touch_byte` is 0, `fifo_not_empty` is 0 and `fifo_rdata` is 0.
- R2: With `filter_en`=1, a window is max(`integ_time`,1) sample ticks long. At the window's last tick, each channel's strength (bits 8n+7:8n of `strength` for channel n) becomes the number of ticks in that window on which its flag was 1. The new value is visible one cycle after that tick, and it holds until the next window ends.
- R3: A channel is never picked unless its strength is strictly greater than its own threshold, given in bits 8n+7:8n of `strength_thr`.
- R4: In mode `afs_mode`=2'b01, only the above-threshold channel with the highest strength is picked. A tie goes to the lower-numbered channel.
- R5: In mode 2'b10, every above-threshold channel is picked.
- R6: In mode 2'b11, the two above-threshold channels with the highest strengths are picked. Ties go to lower-numbered channels.
- R7: Mode 2'b00 picks no channel.
- R8: With `filter_en`=0, each sample tick loads the flags into `touch_byte`, with bit n equal to flag n and all bits at or above the channel count equal to 0. The new byte is visible two cycles after the tick.
- R9: With `filter_en`=1 and `filt_period`=0, `touch_byte` equals the picked set three cycles after a window-ending tick. With `filt_period`=P>0, each channel counts the windows in which it was picked over a run of P windows. At the end of the run, bit n is set only if that count is strictly greater than `filt_thr`. Between run ends, `touch_byte` holds.
- R10: An entry is pushed only when `touch_byte` changes. Entries leave in the order they were pushed. While the FIFO is not empty, `fifo_rdata` shows the oldest entry as {8'h00, touch byte}, and `fifo_pop` removes it.
- R11: A change that occurs while four entries are held is dropped, and the four held entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse marking a sensor sample |
| touch_flags | input | 3 | Per-channel touch flag for the current sample |
| integ_time | input | 8 | Window length in ticks (0 is treated as 1) |
| strength_thr | input | 24 | Per-channel strength thresholds, 8 bits each |
| afs_mode | input | 2 | Selection mode |
| filter_en | input | 1 | 1 enables integration and selection |
| filt_period | input | 8 | Second-stage run length in windows (0 bypasses) |
| filt_thr | input | 8 | Second-stage count threshold |
| fifo_pop | input | 1 | Remove the oldest FIFO entry |
| strength | output | 24 | Per-channel strengths, 8 bits each |
| touch_byte | output | 8 | Current touch byte |
| fifo_rdata | output | 16 | Oldest FIFO entry, or 0 when empty |
| fifo_not_empty | output | 1 | FIFO holds at least one entry |

## Verification
With filtering on, strengths are due one cycle after a window-ending tick, and the bench reads them half a cycle after that edge. The touch byte is due two cycles after a tick in raw mode and three cycles after a window-ending tick when filtering is on. The bench therefore samples the touch byte and FIFO head four negative edges after each tick, once every pipeline stage has settled. FIFO pops are checked half a cycle after the edge that took them, against a bench-side queue that applies the change-only and drop-when-full rules.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SELECT = 2'd1,
        ST_EMIT   = 2'd2
    } tsel_state_e;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_TOP1 = 2'b01,
        MODE_ALL  = 2'b10,
        MODE_TOP2 = 2'b11
    } tsel_mode_e;

endpackage

// File: rtl/tsel_integrator.sv
module tsel_integrator #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          win_end,
    input  logic          flush,
    input  logic          flag,
    output logic [CW-1:0] strength
);

    logic [CW-1:0] acc_q;
    logic [CW-1:0] acc_inc;

    assign acc_inc = acc_q + CW'(flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            strength <= '0;
        end else if (flush) begin
            acc_q <= '0;
        end else if (tick_en) begin
            if (win_end) begin
                strength <= acc_inc;
                acc_q    <= '0;
            end else begin
                acc_q <= acc_inc;
            end
        end
    end

endmodule

// File: rtl/tsel_picker.sv
module tsel_picker #(
    parameter int NCH = 3,
    parameter int CW  = 8
) (
    input  logic [NCH*CW-1:0] strength_flat,
    input  logic [NCH*CW-1:0] thr_flat,
    input  logic [1:0]        mode,
    output logic [NCH-1:0]    sel
);
    import tsel_pkg::*;

    logic [CW-1:0] sv [NCH];
    logic [CW-1:0] tv [NCH];
    logic [NCH-1:0] above;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign sv[g]    = strength_flat[g*CW +: CW];
        assign tv[g]    = thr_flat[g*CW +: CW];
        assign above[g] = sv[g] > tv[g];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_rank
        logic [7:0] rank_c;
        always_comb begin
            rank_c = 8'd0;
            for (int j = 0; j < NCH; j++) begin
                if (j != g && above[j] &&
                    (sv[j] > sv[g] || (sv[j] == sv[g] && j < g)))
                    rank_c = rank_c + 8'd1;
            end
        end
        always_comb begin
            unique case (tsel_mode_e'(mode))
                MODE_TOP1: sel[g] = above[g] && (rank_c == 8'd0);
                MODE_ALL:  sel[g] = above[g];
                MODE_TOP2: sel[g] = above[g] && (rank_c < 8'd2);
                default:   sel[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tsel_fifo.sv
module tsel_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [2*W-1:0]             rdata,
    output logic                       not_empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign not_empty = count != '0;
    assign full      = count == CNTW'(DEPTH);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign rdata     = not_empty ? {{W{1'b0}}, mem[rd_ptr]} : '0;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R11: the occupancy never goes past the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));

    // R11: a push into a full FIFO without a pop leaves it full
    a_r11_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CNTW'(DEPTH)));

endmodule

// File: rtl/touch_strength_sel.sv
module touch_strength_sel #(
    parameter int NCH    = 3,
    parameter int CW     = 8,
    parameter int DEPTH  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic [NCH-1:0]      touch_flags,
    input  logic [CW-1:0]       integ_time,
    input  logic [NCH*CW-1:0]   strength_thr,
    input  logic [1:0]          afs_mode,
    input  logic                filter_en,
    input  logic [CW-1:0]       filt_period,
    input  logic [CW-1:0]       filt_thr,
    input  logic                fifo_pop,
    output logic [NCH*CW-1:0]   strength,
    output logic [BYTE_W-1:0]   touch_byte,
    output logic [2*BYTE_W-1:0] fifo_rdata,
    output logic                fifo_not_empty
);
    import tsel_pkg::*;

    localparam int CNTW = $clog2(DEPTH + 1);

    tsel_state_e         state_q, state_nx;
    logic [CW-1:0]       wcnt_q, run_cnt_q, eff_len;
    logic [CW-1:0]       fcnt_q [NCH];
    logic [BYTE_W-1:0]   cand_q, touch_byte_q;
    logic [NCH-1:0]      sel, run_result;
    logic                win_last, run_last, tick_acc, push;
    logic                fifo_full;
    logic [CNTW-1:0]     fifo_count;

    assign eff_len  = (integ_time == '0) ? CW'(1) : integ_time;
    assign win_last = ({1'b0, wcnt_q} + (CW+1)'(1)) >= {1'b0, eff_len};
    assign run_last = ({1'b0, run_cnt_q} + (CW+1)'(1)) >= {1'b0, filt_period};
    assign tick_acc = (state_q == ST_RUN) && sample_tick && filter_en;

    // per-channel integration
    for (genvar g = 0; g < NCH; g++) begin : g_integ
        tsel_integrator #(.CW(CW)) u_integ (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_acc),
            .win_end  (win_last),
            .flush    (!filter_en),
            .flag     (touch_flags[g]),
            .strength (strength[g*CW +: CW])
        );
    end

    tsel_picker #(.NCH(NCH), .CW(CW)) u_pick (
        .strength_flat (strength),
        .thr_flat      (strength_thr),
        .mode          (afs_mode),
        .sel           (sel)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sample_tick) begin
                    if (!filter_en)    state_nx = ST_EMIT;
                    else if (win_last) state_nx = ST_SELECT;
                end
            end
            ST_SELECT: state_nx = (filt_period == '0 || run_last) ? ST_EMIT : ST_RUN;
            ST_EMIT:   state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wcnt_q <= '0;
        else if (!filter_en) wcnt_q <= '0;
        else if (tick_acc)   wcnt_q <= win_last ? '0 : wcnt_q + CW'(1);
    end

    // second-level run counter and per-channel pick counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_cnt_q <= '0;
        else if (!filter_en) run_cnt_q <= '0;
        else if (state_q == ST_SELECT && filt_period != '0)
            run_cnt_q <= run_last ? '0 : run_cnt_q + CW'(1);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_filt
        assign run_result[g] = ({1'b0, fcnt_q[g]} + (CW+1)'(sel[g])) > {1'b0, filt_thr};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          fcnt_q[g] <= '0;
            else if (!filter_en) fcnt_q[g] <= '0;
            else if (state_q == ST_SELECT && filt_period != '0)
                fcnt_q[g] <= run_last ? '0 : fcnt_q[g] + CW'(sel[g]);
        end
    end

    // candidate byte and touch byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q       <= '0;
            touch_byte_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sample_tick && !filter_en) cand_q <= BYTE_W'(touch_flags);
                end
                ST_SELECT: begin
                    if (filt_period == '0) cand_q <= BYTE_W'(sel);
                    else if (run_last)     cand_q <= BYTE_W'(run_result);
                end
                ST_EMIT:  touch_byte_q <= cand_q;
                default: ;
            endcase
        end
    end

    assign push       = (state_q == ST_EMIT) && (cand_q != touch_byte_q);
    assign touch_byte = touch_byte_q;

    tsel_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wdata     (cand_q),
        .pop       (fifo_pop),
        .rdata     (fifo_rdata),
        .not_empty (fifo_not_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    // R2: strengths move only at the end of a window
    a_r2_strength_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_acc && win_last) |=> $stable(strength));

    // R3: a picked channel is above its own threshold
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        a_r3_pick_above: assert property (@(posedge clk) disable iff (!rst_n)
            sel[g] |-> (strength[g*CW +: CW] > strength_thr[g*CW +: CW]));
    end

    // R4: single-strongest mode picks at most one channel
    a_r4_top1_single: assert property (@(posedge clk) disable iff (!rst_n)
        (afs_mode == 2'b01) |-> $onehot0(sel));

    // R6: two-strongest mode picks at most two channels
    a_r6_top2_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (afs_mode == 2'b11) |-> ($countones(sel) <= 2));

    // R7: the reserved mode picks nothing
    a_r7_reserved_none: assert property (@(posedge clk) disable iff (!rst_n)
        (afs_mode == 2'b00) |-> (sel == '0));

    // R10: a changed byte with room in the FIFO adds exactly one entry
    a_r10_push_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && cand_q != touch_byte_q && !fifo_full && !fifo_pop)
        |=> (fifo_count == CNTW'($past(fifo_count) + 1'b1)));

endmodule

// File: tb/touch_strength_sel_tb.sv
module touch_strength_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_tick;
    logic [2:0]  touch_flags;
    logic [7:0]  integ_time;
    logic [23:0] strength_thr;
    logic [1:0]  afs_mode;
    logic        filter_en;
    logic [7:0]  filt_period;
    logic [7:0]  filt_thr;
    logic        fifo_pop;
    logic [23:0] strength;
    logic [7:0]  touch_byte;
    logic [15:0] fifo_rdata;
    logic        fifo_not_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench-side expected state
    int         m_acc [3];
    int         m_str [3];
    int         m_fc  [3];
    int         m_w, m_run;
    logic [7:0] m_tb;
    logic [7:0] m_q [4];
    int         m_cnt;

    always #4 clk = ~clk;

    touch_strength_sel u_dut (
        .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick),
        .touch_flags (touch_flags), .integ_time (integ_time),
        .strength_thr (strength_thr), .afs_mode (afs_mode),
        .filter_en (filter_en), .filt_period (filt_period),
        .filt_thr (filt_thr), .fifo_pop (fifo_pop),
        .strength (strength), .touch_byte (touch_byte),
        .fifo_rdata (fifo_rdata), .fifo_not_empty (fifo_not_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_pick();
        logic [2:0] above, r;
        int best, second;
        for (int i = 0; i < 3; i++) above[i] = m_str[i] > int'(strength_thr[i*8 +: 8]);
        r = 3'b000;
        best = -1;
        second = -1;
        for (int i = 0; i < 3; i++)
            if (above[i] && (best < 0 || m_str[i] > m_str[best])) best = i;
        for (int i = 0; i < 3; i++)
            if (i != best && above[i] && (second < 0 || m_str[i] > m_str[second])) second = i;
        case (afs_mode)
            2'b01: if (best >= 0) r[best] = 1'b1;
            2'b10: r = above;
            2'b11: begin
                if (best >= 0)   r[best] = 1'b1;
                if (second >= 0) r[second] = 1'b1;
            end
            default: r = 3'b000;
        endcase
        return r;
    endfunction

    task automatic model_new_byte(input logic [7:0] b);
        if (b != m_tb && m_cnt < 4) begin
            m_q[m_cnt] = b;
            m_cnt++;
        end
        m_tb = b;
    endtask

    task automatic check_out(input string req);
        chk(touch_byte == m_tb, req, touch_byte, m_tb);
        chk(fifo_not_empty == (m_cnt > 0), "R10 not_empty", fifo_not_empty, m_cnt > 0);
        if (m_cnt > 0)
            chk(fifo_rdata == {8'h00, m_q[0]}, "R10 head", fifo_rdata, {8'h00, m_q[0]});
    endtask

    task automatic do_reset(input logic fen, input logic [1:0] md, input logic [7:0] it,
                            input logic [23:0] thr, input logic [7:0] fp, input logic [7:0] ft);
        @(negedge clk);
        rst_n = 1'b0;
        sample_tick = 1'b0; touch_flags = 3'b000; fifo_pop = 1'b0;
        filter_en = fen; afs_mode = md; integ_time = it;
        strength_thr = thr; filt_period = fp; filt_thr = ft;
        for (int i = 0; i < 3; i++) begin m_acc[i] = 0; m_str[i] = 0; m_fc[i] = 0; end
        m_w = 0; m_run = 0; m_tb = 8'h00; m_cnt = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick(input logic [2:0] fl, input string req);
        bit wend;
        int eff;
        logic [2:0] s;
        wend = 0;
        @(negedge clk);
        sample_tick = 1'b1;
        touch_flags = fl;
        @(negedge clk);
        sample_tick = 1'b0;
        if (!filter_en) begin
            model_new_byte({5'b0, fl});
        end else begin
            eff = (integ_time == 0) ? 1 : int'(integ_time);
            for (int i = 0; i < 3; i++) m_acc[i] += int'(fl[i]);
            m_w++;
            if (m_w >= eff) begin
                wend = 1;
                m_w = 0;
                for (int i = 0; i < 3; i++) begin m_str[i] = m_acc[i]; m_acc[i] = 0; end
            end
        end
        if (wend) begin
            for (int i = 0; i < 3; i++)
                chk(int'(strength[i*8 +: 8]) == m_str[i], "R2 strength", strength[i*8 +: 8], m_str[i]);
            s = exp_pick();
            if (filt_period == 0) begin
                model_new_byte({5'b0, s});
            end else begin
                for (int i = 0; i < 3; i++) m_fc[i] += int'(s[i]);
                m_run++;
                if (m_run >= int'(filt_period)) begin
                    logic [7:0] b;
                    b = 8'h00;
                    for (int i = 0; i < 3; i++) begin
                        b[i] = m_fc[i] > int'(filt_thr);
                        m_fc[i] = 0;
                    end
                    m_run = 0;
                    model_new_byte(b);
                end
            end
        end
        repeat (3) @(negedge clk);
        check_out(req);
    endtask

    task automatic pop_one();
        @(negedge clk);
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        if (m_cnt > 0) begin
            for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
            m_cnt--;
        end
        check_out("R10 pop");
    endtask

    function automatic logic [2:0] rnd_flags();
        logic [2:0] f;
        for (int i = 0; i < 3; i++) f[i] = ($urandom % 8) < (2 + 2*i);
        return f;
    endfunction

    task automatic rand_run(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            tick(rnd_flags(), req);
            if ($urandom % 3 == 0) pop_one();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        // R1: reset state
        do_reset(1'b0, 2'b10, 8'h0F, 24'h010101, 8'h00, 8'h00);
        chk(strength == 24'h0, "R1 strength", strength, 0);
        chk(touch_byte == 8'h00, "R1 touch_byte", touch_byte, 0);
        chk(fifo_not_empty == 1'b0, "R1 not_empty", fifo_not_empty, 0);
        chk(fifo_rdata == 16'h0, "R1 rdata", fifo_rdata, 0);

        // R10: unchanged byte pushes nothing
        tick(3'b000, "R10 no change");
        // R8: raw flags pass through
        rand_run(20, "R8 raw");

        // R11: fill FIFO with changes, extra changes dropped
        do_reset(1'b0, 2'b10, 8'h0F, 24'h010101, 8'h00, 8'h00);
        tick(3'b001, "R11 fill"); tick(3'b010, "R11 fill");
        tick(3'b011, "R11 fill"); tick(3'b100, "R11 fill");
        tick(3'b101, "R11 drop"); tick(3'b110, "R11 drop");
        repeat (5) pop_one();
        tick(3'b111, "R11 after drain");

        // R2 R3 R5: all above threshold
        do_reset(1'b1, 2'b10, 8'd4, {8'd2, 8'd1, 8'd1}, 8'h00, 8'h00);
        rand_run(60, "R5 all");
        // R4: single strongest
        do_reset(1'b1, 2'b01, 8'd4, {8'd1, 8'd0, 8'd1}, 8'h00, 8'h00);
        rand_run(60, "R4 top1");
        // R6: two strongest
        do_reset(1'b1, 2'b11, 8'd5, {8'd0, 8'd1, 8'd0}, 8'h00, 8'h00);
        rand_run(60, "R6 top2");
        // R7: reserved mode
        do_reset(1'b1, 2'b00, 8'd2, 24'h000000, 8'h00, 8'h00);
        tick(3'b111, "R7 none"); tick(3'b111, "R7 none");

        // R4 R6 ties: equal strengths go to lower channels
        do_reset(1'b1, 2'b01, 8'd2, 24'h000000, 8'h00, 8'h00);
        tick(3'b111, "R4 tie"); tick(3'b111, "R4 tie");
        do_reset(1'b1, 2'b11, 8'd2, 24'h000000, 8'h00, 8'h00);
        tick(3'b111, "R6 tie"); tick(3'b111, "R6 tie");
        // R3: strength equal to threshold is not picked
        do_reset(1'b1, 2'b10, 8'd2, {8'd2, 8'd1, 8'd2}, 8'h00, 8'h00);
        tick(3'b111, "R3 at thr"); tick(3'b111, "R3 at thr");

        // R2: integ_time 0 acts as one tick
        do_reset(1'b1, 2'b10, 8'd0, 24'h000000, 8'h00, 8'h00);
        rand_run(12, "R2 one-tick window");

        // R9: second-level filter
        do_reset(1'b1, 2'b10, 8'd2, 24'h000000, 8'd3, 8'd1);
        rand_run(60, "R9 second stage");
        do_reset(1'b1, 2'b11, 8'd1, {8'd0, 8'd0, 8'd0}, 8'd2, 8'd0);
        rand_run(30, "R9 second stage top2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule